// File: doc/BRIEF.md
# Haptic Driver Start Sequencer

This block is the control state machine that brings a haptic actuator driver from a start request to active drive. A one-cycle enable request begins a preparation phase. That phase gives one cycle to mode setup and then waits until the supply reports that precharge is complete and the safety checks report a pass. The block then either drives at once (open-loop) or first runs a resonance search. The search has a fixed detection window followed by a lock wait of variable length. If lock does not come within a programmable number of cycles, the block falls back to open-loop drive and raises a flag.

On entry to drive, the block emits a one-cycle start pulse, so the latency from request to drive can be timed. It also enables a ramp whose level rises by a programmable step each cycle and saturates, so drive does not begin as a step. An undervoltage or overcurrent indication aborts the sequence in any active state. After an abort, the block ignores requests for a programmable recovery count.

An arm input keeps the precharge request asserted while the block is idle. With it, the first actuation after a quiet period has the same start latency as every later one.

Top module: `haptic_start_seq`

## Requirements
- R1: `state_o` encodes idle=0, prep=1, detect=2, lock=3, drive=4, and resets to 0. Without an abort or stop, states are only visited in the order idle, prep, detect, lock, drive, with detect and lock present only in closed-loop mode.
- R2: An accepted request enters prep. The first prep cycle is a setup cycle. From the second prep cycle on, prep is left at the clock edge where `precharge_done_i` and `safety_ok_i` are both high.
- R3: The mode is `closed_loop_i` sampled with the accepted request. In open-loop mode (0), prep goes directly to drive. With inputs ready, drive is entered 3 edges after the request edge.
- R4: In closed-loop mode, detect lasts exactly DET_LEN cycles and then becomes lock. Lock moves to drive at the edge where `lock_i` is high.
- R5: If drive has not been reached after `lock_timeout_i` cycles counted from detect entry, the block enters drive and sets `fallback_o`. When lock and timeout occur in the same cycle, lock wins. `fallback_o` stays set until the next accepted request.
- R6: `drive_start_o` is high for exactly the first cycle of each drive visit.
- R7: `ramp_en_o` is high exactly in drive. `ramp_lvl_o` is 0 outside drive and in the first drive cycle, then rises by `slew_i` per cycle, saturating at 2^LVL_W-1.
- R8: `fault_i` in any non-idle state returns the block to idle at the next edge. It loads a recovery count of `recov_len_i`, which decrements once per idle cycle. `recovering_o` is high while the count is non-zero, and requests are ignored during that time. `fault_i` while idle has no effect.
- R9: `precharge_o` is high in every non-idle state. While idle, it follows `arm_i` except during recovery.
- R10: `stop_i` in drive returns the block to idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Start request pulse |
| closed_loop_i | input | 1 | Mode select, 1 = closed-loop |
| arm_i | input | 1 | Hold precharge while idle |
| precharge_done_i | input | 1 | Supply precharge complete |
| safety_ok_i | input | 1 | Safety checks passed |
| lock_i | input | 1 | Resonance lock achieved |
| fault_i | input | 1 | Undervoltage or overcurrent |
| stop_i | input | 1 | End of drive |
| lock_timeout_i | input | CNT_W | Cycles allowed for detect plus lock |
| recov_len_i | input | CNT_W | Recovery count after an abort |
| slew_i | input | LVL_W | Ramp step per cycle |
| precharge_o | output | 1 | Precharge request to supply |
| drive_start_o | output | 1 | One-cycle pulse on drive entry |
| ramp_en_o | output | 1 | Ramp active |
| ramp_lvl_o | output | LVL_W | Ramp level |
| state_o | output | 3 | Current state code |
| fallback_o | output | 1 | Lock timed out, drive is open-loop |
| recovering_o | output | 1 | Post-abort recovery in progress |

## Verification
The bench builds the block with CNT_W=8, LVL_W=6 and DET_LEN=3. The 6-bit ramp saturates within a few drive cycles, so the saturation corner is reached often. The 3-cycle detect window lets lock timeouts of 2 to 12 cycles fall both inside detect and inside lock, which exercises a timeout during detect and a tie between lock and timeout. Small recovery counts, including zero, let requests arrive both during recovery and on the first cycle after it.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PREP   = 3'd1,
    ST_DETECT = 3'd2,
    ST_LOCK   = 3'd3,
    ST_DRIVE  = 3'd4
  } hsq_state_e;
endpackage

// File: rtl/hsq_recov.sv
module hsq_recov #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             idle_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= len_i;
    else if (idle_i && busy_o)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/hsq_watch.sv
module hsq_watch #(
  parameter int CNT_W   = 16,
  parameter int DET_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CNT_W-1:0] timeout_i,
  output logic             det_done_o,
  output logic             tmo_o
);
  localparam logic [CNT_W-1:0] DET_LAST = CNT_W'(DET_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   elapsed;

  // cycles spent in the closed-loop phase, cleared on every other state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (active_i) cnt_q <= cnt_q + 1'b1;
    else               cnt_q <= '0;
  end

  assign elapsed    = {1'b0, cnt_q} + 1'b1;
  assign det_done_o = (cnt_q == DET_LAST);
  assign tmo_o      = (elapsed >= {1'b0, timeout_i});
endmodule

// File: rtl/hsq_ramp.sv
module hsq_ramp #(
  parameter int LVL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LVL_W-1:0] step_i,
  output logic [LVL_W-1:0] lvl_o
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W:0]   sum;

  assign sum = {1'b0, lvl_q} + {1'b0, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lvl_q <= '0;
    else if (!run_i)    lvl_q <= '0;
    else if (sum[LVL_W]) lvl_q <= LVL_MAX;
    else                lvl_q <= sum[LVL_W-1:0];
  end

  assign lvl_o = run_i ? lvl_q : '0;
endmodule

// File: rtl/hsq_fsm.sv
module hsq_fsm
  import hsq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       closed_loop_i,
  input  logic       precharge_done_i,
  input  logic       safety_ok_i,
  input  logic       lock_i,
  input  logic       fault_i,
  input  logic       stop_i,
  input  logic       recov_busy_i,
  input  logic       det_done_i,
  input  logic       tmo_i,
  output hsq_state_e state_o,
  output logic       fallback_o,
  output logic       abort_o,
  output logic       drive_start_o
);
  hsq_state_e state_q, state_d;
  logic setup_q, setup_d, cl_q, cl_d, fb_q, fb_d, in_drv_q;

  always_comb begin
    state_d = state_q;
    setup_d = setup_q;
    cl_d    = cl_q;
    fb_d    = fb_q;
    abort_o = 1'b0;
    if (fault_i && state_q != ST_IDLE) begin
      state_d = ST_IDLE;
      abort_o = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (en_i && !recov_busy_i) begin
          state_d = ST_PREP;
          cl_d    = closed_loop_i;
          fb_d    = 1'b0;
          setup_d = 1'b1;
        end
        ST_PREP: begin
          if (setup_q) setup_d = 1'b0;
          else if (precharge_done_i && safety_ok_i)
            state_d = cl_q ? ST_DETECT : ST_DRIVE;
        end
        ST_DETECT: begin
          if (tmo_i) begin
            state_d = ST_DRIVE;
            fb_d    = 1'b1;
          end else if (det_done_i) state_d = ST_LOCK;
        end
        ST_LOCK: begin
          if (lock_i) state_d = ST_DRIVE;
          else if (tmo_i) begin
            state_d = ST_DRIVE;
            fb_d    = 1'b1;
          end
        end
        ST_DRIVE: if (stop_i) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      setup_q  <= 1'b0;
      cl_q     <= 1'b0;
      fb_q     <= 1'b0;
      in_drv_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      setup_q  <= setup_d;
      cl_q     <= cl_d;
      fb_q     <= fb_d;
      in_drv_q <= (state_q == ST_DRIVE);
    end
  end

  assign state_o       = state_q;
  assign fallback_o    = fb_q;
  assign drive_start_o = (state_q == ST_DRIVE) && !in_drv_q;
endmodule

// File: rtl/haptic_start_seq.sv
module haptic_start_seq
  import hsq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int LVL_W   = 10,
  parameter int DET_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             closed_loop_i,
  input  logic             arm_i,
  input  logic             precharge_done_i,
  input  logic             safety_ok_i,
  input  logic             lock_i,
  input  logic             fault_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] lock_timeout_i,
  input  logic [CNT_W-1:0] recov_len_i,
  input  logic [LVL_W-1:0] slew_i,
  output logic             precharge_o,
  output logic             drive_start_o,
  output logic             ramp_en_o,
  output logic [LVL_W-1:0] ramp_lvl_o,
  output logic [2:0]       state_o,
  output logic             fallback_o,
  output logic             recovering_o
);
  hsq_state_e st;
  logic abort, recov_busy, det_done, tmo, in_cl, in_drive;

  assign in_cl    = (st == ST_DETECT) || (st == ST_LOCK);
  assign in_drive = (st == ST_DRIVE);

  hsq_fsm u_fsm (
    .clk_i, .rst_ni, .en_i, .closed_loop_i, .precharge_done_i, .safety_ok_i,
    .lock_i, .fault_i, .stop_i,
    .recov_busy_i (recov_busy),
    .det_done_i   (det_done),
    .tmo_i        (tmo),
    .state_o      (st),
    .fallback_o   (fallback_o),
    .abort_o      (abort),
    .drive_start_o(drive_start_o)
  );

  hsq_watch #(.CNT_W(CNT_W), .DET_LEN(DET_LEN)) u_watch (
    .clk_i, .rst_ni,
    .active_i  (in_cl),
    .timeout_i (lock_timeout_i),
    .det_done_o(det_done),
    .tmo_o     (tmo)
  );

  hsq_recov #(.CNT_W(CNT_W)) u_recov (
    .clk_i, .rst_ni,
    .load_i(abort),
    .len_i (recov_len_i),
    .idle_i(st == ST_IDLE),
    .busy_o(recov_busy)
  );

  hsq_ramp #(.LVL_W(LVL_W)) u_ramp (
    .clk_i, .rst_ni,
    .run_i (in_drive),
    .step_i(slew_i),
    .lvl_o (ramp_lvl_o)
  );

  assign ramp_en_o    = in_drive;
  assign state_o      = st;
  assign recovering_o = recov_busy;
  assign precharge_o  = (st != ST_IDLE) || (arm_i && !recov_busy);
endmodule

// File: rtl/hsq_checker.sv
module hsq_checker
  import hsq_pkg::*;
#(
  parameter int LVL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             precharge_done_i,
  input logic             safety_ok_i,
  input logic             fault_i,
  input logic             precharge_o,
  input logic             drive_start_o,
  input logic [LVL_W-1:0] ramp_lvl_o,
  input logic [2:0]       state_o,
  input logic             recovering_o
);
  assert_drive_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DRIVE && $past(state_o) != ST_DRIVE) |->
      ($past(state_o) == ST_PREP || $past(state_o) == ST_DETECT || $past(state_o) == ST_LOCK));

  assert_prep_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == ST_PREP && (state_o == ST_DETECT || state_o == ST_DRIVE)) |->
      $past(precharge_done_i && safety_ok_i));

  assert_start_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_start_o |=> !drive_start_o);

  assert_start_in_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_start_o |-> (state_o == ST_DRIVE && ramp_lvl_o == '0));

  assert_ramp_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DRIVE && $past(state_o) == ST_DRIVE) |-> ramp_lvl_o >= $past(ramp_lvl_o));

  assert_fault_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && state_o != ST_IDLE) |=> state_o == ST_IDLE);

  assert_recov_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recovering_o && en_i) |=> state_o == ST_IDLE);

  assert_precharge_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_IDLE) |-> precharge_o);
endmodule

bind haptic_start_seq hsq_checker #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/haptic_start_seq_bench.sv
`timescale 1ns/1ps
module haptic_start_seq_bench;
  localparam int CW = 8, LW = 6, DL = 3;
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 0, cl = 0, arm = 0, pd = 1, so = 1, lk = 0, flt = 0, stp = 0;
  logic [CW-1:0] tmo_v = 8'd5, rec_v = 8'd4;
  logic [LW-1:0] slew_v = 6'd20;
  logic pre_o, ds_o, ren_o, fb_o, rec_o;
  logic [LW-1:0] lvl_o;
  logic [2:0] st_o;

  always #2.5 clk = ~clk;

  haptic_start_seq #(.CNT_W(CW), .LVL_W(LW), .DET_LEN(DL)) u_haptic_start_seq (
    .clk_i(clk), .rst_ni, .en_i(en), .closed_loop_i(cl), .arm_i(arm),
    .precharge_done_i(pd), .safety_ok_i(so), .lock_i(lk), .fault_i(flt), .stop_i(stp),
    .lock_timeout_i(tmo_v), .recov_len_i(rec_v), .slew_i(slew_v),
    .precharge_o(pre_o), .drive_start_o(ds_o), .ramp_en_o(ren_o), .ramp_lvl_o(lvl_o),
    .state_o(st_o), .fallback_o(fb_o), .recovering_o(rec_o)
  );

  int vecs = 0, errs = 0;
  int m_st = 0, m_prev = 0, m_k = 0, m_r = 0, m_lvl = 0, m_cl = 0, m_fb = 0, m_setup = 0;

  task automatic chk(string tag, int act, int exp);
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    vecs++;
    chk("R1 R2 R3 R4 R10 state", int'(st_o), m_st);
    chk("R6 drive_start", int'(ds_o), int'(m_st == 4 && m_prev != 4));
    chk("R7 ramp_en", int'(ren_o), int'(m_st == 4));
    chk("R7 ramp_lvl", int'(lvl_o), (m_st == 4) ? m_lvl : 0);
    chk("R5 fallback", int'(fb_o), m_fb);
    chk("R8 recovering", int'(rec_o), int'(m_r != 0));
    chk("R9 precharge", int'(pre_o), int'(m_st != 0 || (arm && m_r == 0)));
  endtask

  task automatic model_step();
    int ost, nlvl;
    ost = m_st;
    m_prev = m_st;
    nlvl = (ost == 4) ? ((m_lvl + int'(slew_v) > LMAX) ? LMAX : m_lvl + int'(slew_v)) : 0;
    if (flt && ost != 0) begin
      m_st = 0; m_r = int'(rec_v);
    end else begin
      case (ost)
        0: if (m_r > 0) m_r--;
           else if (en) begin m_st = 1; m_cl = int'(cl); m_fb = 0; m_setup = 1; end
        1: if (m_setup == 1) m_setup = 0;
           else if (pd && so) m_st = m_cl ? 2 : 4;
        2: if (m_k + 1 >= int'(tmo_v)) begin m_st = 4; m_fb = 1; end
           else if (m_k == DL - 1) m_st = 3;
        3: if (lk) m_st = 4;
           else if (m_k + 1 >= int'(tmo_v)) begin m_st = 4; m_fb = 1; end
        4: if (stp) m_st = 0;
        default: m_st = 0;
      endcase
    end
    m_k = (ost == 2 || ost == 3) ? m_k + 1 : 0;
    m_lvl = nlvl;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic pulse_en(input logic mode);
    cl = mode; en = 1; tick(); en = 0;
  endtask

  // counts edges from the request edge to the drive_start pulse
  task automatic latency(input logic mode, output int n);
    n = 1;
    pulse_en(mode);
    for (int i = 0; i < 60 && !ds_o; i++) begin tick(); n++; end
  endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk); compare();            // reset state R1
    rst_ni = 1; tick();

    // R3, R9: armed open-loop start, fixed 3-edge latency
    arm = 1; tick(); vecs++; if (pre_o !== 1'b1) begin errs++; $display("FAIL R9 armed idle precharge actual=%0d expected=1", pre_o); end
    latency(1'b0, n); vecs++; if (n != 3) begin errs++; $display("FAIL R3 open-loop latency actual=%0d expected=3", n); end
    repeat (12) tick();                   // R7: 0,20,40,60,63,63...
    stp = 1; tick(); stp = 0;             // R10
    // R2: prep waits for safety
    so = 0; pulse_en(1'b0); repeat (5) tick(); so = 1; repeat (2) tick();
    stp = 1; tick(); stp = 0;
    // R4: closed-loop with lock high: 3 + DL + 1
    lk = 1; tmo_v = 20;
    latency(1'b1, n); vecs++; if (n != 7) begin errs++; $display("FAIL R4 lock latency actual=%0d expected=7", n); end
    stp = 1; tick(); stp = 0; lk = 0;
    // R5: timeout 5, no lock
    tmo_v = 5;
    latency(1'b1, n); vecs++; if (n != 8 || fb_o !== 1'b1) begin errs++; $display("FAIL R5 timeout latency/flag actual=%0d/%0d expected=8/1", n, fb_o); end
    stp = 1; tick(); stp = 0;
    // R5: timeout inside detect
    tmo_v = 2; latency(1'b1, n); tick();
    stp = 1; tick(); stp = 0;
    // R8: abort in drive, requests ignored while recovering
    tmo_v = 20; pulse_en(1'b0); repeat (4) tick();
    flt = 1; tick(); flt = 0;
    pulse_en(1'b0); vecs++; if (st_o !== 3'd0) begin errs++; $display("FAIL R8 request in recovery actual=%0d expected=0", st_o); end
    repeat (4) tick();
    flt = 1; tick(); flt = 0;              // R8: fault in idle has no effect
    pulse_en(1'b0); vecs++; if (st_o !== 3'd1) begin errs++; $display("FAIL R8 request after recovery actual=%0d expected=1", st_o); end
    repeat (3) tick(); stp = 1; tick(); stp = 0;

    // mixed stimulus
    for (int c = 0; c < 6000; c++) begin
      if (c % 250 == 0) begin
        tmo_v  = 8'(2 + ($urandom % 11));
        rec_v  = 8'($urandom % 5);
        slew_v = 6'($urandom % 64);
        arm    = 1'($urandom % 2);
      end
      en  = ($urandom % 8) == 0;
      cl  = 1'($urandom % 2);
      pd  = ($urandom % 4) != 0;
      so  = ($urandom % 4) != 0;
      lk  = ($urandom % 6) == 0;
      flt = ($urandom % 60) == 0;
      stp = ($urandom % 20) == 0;
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule